// File: doc/BRIEF.md
# Keyboard Scancode Message Collector

This block sits behind a PS/2 byte receiver and turns a stream of set-2 scancode bytes, each flagged by a one-cycle strobe, into ASCII characters. It keeps its own Shift and Caps Lock state, drops key-release sequences, and understands the two-byte extended codes. This lets extended Delete be told apart from the keypad key that has the same second byte.

Every character it produces is written into a 128-bit message register at the byte slot given by its position in the message. The first character goes into the lowest byte. When the sixteenth character lands, a completion flag rises, and the register can be handed to a 128-bit block cipher as one plaintext block. The flag stays high until a synchronous reset. Any character that arrives while the flag is high is discarded. Reset clears the position counter, the flag and the modifiers, but not the message bytes. A short message therefore leaves older bytes in the slots it never reached.

Top module: `ps2_char_accum`

## Requirements
- R1: Each accepted byte passes through four control states in a fixed order: idle, fetch, decode, emit, then back to idle. A strobe is accepted only in idle, and a strobe that arrives in any other state is ignored. A produced character is visible on `msg_o` after the fourth rising edge, counting the edge that samples the strobe.
- R2: Letter scancodes (A=0x1C, B=0x32, C=0x21, D=0x23, E=0x24, F=0x2B and the rest of the US layout) give upper case (0x41..0x5A) when exactly one of Shift and Caps Lock is active. They give lower case (0x61..0x7A) when neither or both are active.
- R3: Digit keys (0x45, 0x16, 0x1E, 0x26, 0x25, 0x2E, 0x36, 0x3D, 0x3E, 0x46 for 0..9) give 0x30..0x39. With Shift held they give the US symbols `)!@#$%^&*(`.
- R4: Control keys translate as follows: 0x29 gives 0x20, 0x66 gives 0x08, 0x0D gives 0x09, 0x5A gives 0x0D and 0x76 gives 0x1B. The extended pair 0xE0 0x71 gives 0x7F, while a plain 0x71 gives 0x2E.
- R5: The n-th character since reset (n = 1..16) is stored in bits 8n-1 down to 8n-8 of `msg_o`.
- R6: `done_o` rises on the edge that stores the sixteenth character and stays high until reset. While it is high, further characters leave `msg_o` unchanged.
- R7: Reset does not alter `msg_o`. Byte slots not written since the last reset keep their earlier contents.
- R8: 0xF0 marks the next code as a release. A release produces no character. Releasing 0x12 or 0x59 clears the Shift state, which pressing either of those keys sets.
- R9: 0xE0 applies only to the next non-prefix code. A code after that is decoded as non-extended.
- R10: Pressing 0x58 toggles Caps Lock. Releasing it has no effect.
- R11: Scancodes with no mapping, including extended codes other than 0x71, produce no character and do not advance the position.
- R12: After reset `done_o` is low, Shift and Caps Lock are off, and the next character is stored in byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| scan_i | input | 8 | Scancode byte from the PS/2 receiver |
| scan_vld_i | input | 1 | One-cycle strobe qualifying `scan_i` |
| msg_o | output | 128 | Collected message, first character in bits 7:0 |
| done_o | output | 1 | High once sixteen characters are stored |

## Verification
The hardest conditions to reach from the ports involve a reset that lands on a partly overwritten message, and a strobe that arrives while the decoder is still busy. The stimulus fills all sixteen slots first, resets, and then types only two characters, so the retained upper bytes can be compared against the first session. A second strobe is placed exactly one cycle after an accepted one, and the bench checks that it never becomes a character. The reference model tracks modifiers and prefixes behaviourally and is compared against the outputs on every falling edge. This also pins down the four-edge character latency.

// File: rtl/ps2acc_pkg.sv
package ps2acc_pkg;

    localparam int CHAR_W  = 8;
    localparam int N_CHARS = 16;

    localparam logic [7:0] SC_BREAK  = 8'hF0;
    localparam logic [7:0] SC_EXT    = 8'hE0;
    localparam logic [7:0] SC_LSHIFT = 8'h12;
    localparam logic [7:0] SC_RSHIFT = 8'h59;
    localparam logic [7:0] SC_CAPS   = 8'h58;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_EMIT   = 2'd3
    } fsm_e;

    typedef struct packed {
        fsm_e        state;
        logic [7:0]  code;
        logic        brk;
        logic        ext;
        logic        shift;
        logic        caps;
        logic [7:0]  ch;
        logic        ch_ok;
    } ctl_t;

endpackage

// File: rtl/scan_xlate.sv
module scan_xlate (
    input  logic [7:0] code_i,
    input  logic       ext_i,
    input  logic       shift_i,
    input  logic       caps_i,
    output logic [7:0] ch_o,
    output logic       ok_o
);
    logic [7:0] letter;
    logic [7:0] plain;
    logic [7:0] shifted;
    logic       is_letter;
    logic       is_other;

    // letters: upper-case code, case chosen below
    always_comb begin
        is_letter = 1'b1;
        case (code_i)
            8'h1C: letter = 8'h41;  8'h32: letter = 8'h42;  8'h21: letter = 8'h43;
            8'h23: letter = 8'h44;  8'h24: letter = 8'h45;  8'h2B: letter = 8'h46;
            8'h34: letter = 8'h47;  8'h33: letter = 8'h48;  8'h43: letter = 8'h49;
            8'h3B: letter = 8'h4A;  8'h42: letter = 8'h4B;  8'h4B: letter = 8'h4C;
            8'h3A: letter = 8'h4D;  8'h31: letter = 8'h4E;  8'h44: letter = 8'h4F;
            8'h4D: letter = 8'h50;  8'h15: letter = 8'h51;  8'h2D: letter = 8'h52;
            8'h1B: letter = 8'h53;  8'h2C: letter = 8'h54;  8'h3C: letter = 8'h55;
            8'h2A: letter = 8'h56;  8'h1D: letter = 8'h57;  8'h22: letter = 8'h58;
            8'h35: letter = 8'h59;  8'h1A: letter = 8'h5A;
            default: begin letter = 8'h00; is_letter = 1'b0; end
        endcase
    end

    // digits, symbols and control keys (non-extended)
    always_comb begin
        is_other = 1'b1;
        shifted  = 8'h00;
        case (code_i)
            8'h45: begin plain = 8'h30; shifted = 8'h29; end
            8'h16: begin plain = 8'h31; shifted = 8'h21; end
            8'h1E: begin plain = 8'h32; shifted = 8'h40; end
            8'h26: begin plain = 8'h33; shifted = 8'h23; end
            8'h25: begin plain = 8'h34; shifted = 8'h24; end
            8'h2E: begin plain = 8'h35; shifted = 8'h25; end
            8'h36: begin plain = 8'h36; shifted = 8'h5E; end
            8'h3D: begin plain = 8'h37; shifted = 8'h26; end
            8'h3E: begin plain = 8'h38; shifted = 8'h2A; end
            8'h46: begin plain = 8'h39; shifted = 8'h28; end
            8'h29: begin plain = 8'h20; shifted = 8'h20; end
            8'h66: begin plain = 8'h08; shifted = 8'h08; end
            8'h0D: begin plain = 8'h09; shifted = 8'h09; end
            8'h5A: begin plain = 8'h0D; shifted = 8'h0D; end
            8'h76: begin plain = 8'h1B; shifted = 8'h1B; end
            8'h71: begin plain = 8'h2E; shifted = 8'h2E; end
            default: begin plain = 8'h00; is_other = 1'b0; end
        endcase
    end

    always_comb begin
        ch_o = 8'h00;
        ok_o = 1'b0;
        if (ext_i) begin
            if (code_i == 8'h71) begin
                ch_o = 8'h7F;
                ok_o = 1'b1;
            end
        end else if (is_letter) begin
            ch_o = (shift_i ^ caps_i) ? letter : (letter | 8'h20);
            ok_o = 1'b1;
        end else if (is_other) begin
            ch_o = shift_i ? shifted : plain;
            ok_o = 1'b1;
        end
    end

endmodule

// File: rtl/msg_packer.sv
module msg_packer #(
    parameter int N_CHARS = 16,
    parameter int CHAR_W  = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       wr_i,
    input  logic [CHAR_W-1:0]          ch_i,
    output logic [N_CHARS*CHAR_W-1:0]  msg_o,
    output logic                       done_o
);
    localparam int CNT_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CHARS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [N_CHARS*CHAR_W-1:0] msg_d, msg_q;

    always_comb begin
        pos_d = pos_q;
        msg_d = msg_q;
        if (wr_i && !pos_q.done) begin
            msg_d[pos_q.cnt*CHAR_W +: CHAR_W] = ch_i;
            if (pos_q.cnt == LAST) pos_d.done = 1'b1;
            else                   pos_d.cnt  = pos_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pos_q <= '0;
        else       pos_q <= pos_d;
    end

    // message bytes are deliberately kept across reset
    always_ff @(posedge clk_i) begin
        msg_q <= msg_d;
    end

    assign msg_o  = msg_q;
    assign done_o = pos_q.done;

    p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q.done |=> pos_q.done);
    p_msg_frozen_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q.done |=> $stable(msg_q));
    p_no_write_after_done_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |-> !pos_q.done);
    p_idle_keeps_msg_r7: assert property (@(posedge clk_i)
        !wr_i |=> $stable(msg_q));

endmodule

// File: rtl/ps2_char_accum.sv
module ps2_char_accum
    import ps2acc_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [7:0]   scan_i,
    input  logic         scan_vld_i,
    output logic [127:0] msg_o,
    output logic         done_o
);
    ctl_t       c_d, c_q;
    logic [7:0] x_ch;
    logic       x_ok;
    logic       wr;
    logic       is_shift_key;

    scan_xlate i_xlate (
        .code_i  (c_q.code),
        .ext_i   (c_q.ext),
        .shift_i (c_q.shift),
        .caps_i  (c_q.caps),
        .ch_o    (x_ch),
        .ok_o    (x_ok)
    );

    assign is_shift_key = (c_q.code == SC_LSHIFT) || (c_q.code == SC_RSHIFT);

    always_comb begin
        c_d = c_q;
        wr  = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (scan_vld_i) begin
                    c_d.code  = scan_i;
                    c_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (c_q.code == SC_BREAK) begin
                    c_d.brk   = 1'b1;
                    c_d.state = ST_IDLE;
                end else if (c_q.code == SC_EXT) begin
                    c_d.ext   = 1'b1;
                    c_d.state = ST_IDLE;
                end else begin
                    c_d.state = ST_DECODE;
                end
            end
            ST_DECODE: begin
                c_d.ch_ok = 1'b0;
                c_d.ch    = x_ch;
                if (c_q.brk) begin
                    if (!c_q.ext && is_shift_key) c_d.shift = 1'b0;
                end else if (!c_q.ext && is_shift_key) begin
                    c_d.shift = 1'b1;
                end else if (!c_q.ext && c_q.code == SC_CAPS) begin
                    c_d.caps = ~c_q.caps;
                end else begin
                    c_d.ch_ok = x_ok;
                end
                c_d.state = ST_EMIT;
            end
            default: begin
                wr        = c_q.ch_ok;
                c_d.brk   = 1'b0;
                c_d.ext   = 1'b0;
                c_d.ch_ok = 1'b0;
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) c_q <= '0;
        else       c_q <= c_d;
    end

    msg_packer #(.N_CHARS(N_CHARS), .CHAR_W(CHAR_W)) i_packer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wr_i   (wr && !done_o),
        .ch_i   (c_q.ch),
        .msg_o  (msg_o),
        .done_o (done_o)
    );

    p_fetch_next_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.state == ST_FETCH |=> (c_q.state == ST_IDLE || c_q.state == ST_DECODE));
    p_decode_next_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.state == ST_DECODE |=> c_q.state == ST_EMIT);
    p_emit_next_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.state == ST_EMIT |=> c_q.state == ST_IDLE);
    p_caps_only_decode_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.state != ST_DECODE |=> $stable(c_q.caps));
    p_shift_only_decode_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.state != ST_DECODE |=> $stable(c_q.shift));
    p_prefix_cleared_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.state == ST_EMIT |=> (!c_q.ext && !c_q.brk));

endmodule

// File: tb/test_ps2_char_accum.sv
module test_ps2_char_accum;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   scan = 8'h00;
    logic         vld = 1'b0;
    logic [127:0] msg;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [7:0] m_msg [16];
    bit         m_known [16];
    int         m_cnt = 0;
    bit         m_done = 0, m_shift = 0, m_caps = 0, m_brk = 0, m_ext = 0;

    logic [7:0] letter_sc [26] = '{8'h1C,8'h32,8'h21,8'h23,8'h24,8'h2B,8'h34,8'h33,
        8'h43,8'h3B,8'h42,8'h4B,8'h3A,8'h31,8'h44,8'h4D,8'h15,8'h2D,8'h1B,8'h2C,
        8'h3C,8'h2A,8'h1D,8'h22,8'h35,8'h1A};
    logic [7:0] digit_sc [10] = '{8'h45,8'h16,8'h1E,8'h26,8'h25,8'h2E,8'h36,8'h3D,8'h3E,8'h46};
    string digit_sym = ")!@#$%^&*(";

    always #10 clk = ~clk;

    ps2_char_accum i_ps2_char_accum (
        .clk_i(clk), .rst_i(rst), .scan_i(scan), .scan_vld_i(vld),
        .msg_o(msg), .done_o(done)
    );

    function automatic bit ref_xlate(input logic [7:0] c, output logic [7:0] ch);
        ch = 8'h00;
        if (m_ext) begin
            if (c == 8'h71) begin ch = 8'h7F; return 1; end
            return 0;
        end
        for (int i = 0; i < 26; i++)
            if (letter_sc[i] == c) begin
                ch = 8'(((m_shift != m_caps) ? 65 : 97) + i);
                return 1;
            end
        for (int i = 0; i < 10; i++)
            if (digit_sc[i] == c) begin
                ch = m_shift ? 8'(digit_sym[i]) : 8'(48 + i);
                return 1;
            end
        case (c)
            8'h29: ch = 8'h20;
            8'h66: ch = 8'h08;
            8'h0D: ch = 8'h09;
            8'h5A: ch = 8'h0D;
            8'h76: ch = 8'h1B;
            8'h71: ch = 8'h2E;
            default: return 0;
        endcase
        return 1;
    endfunction

    task automatic model_apply(input logic [7:0] c);
        logic [7:0] ch;
        bit is_sh;
        if (c == 8'hF0) begin m_brk = 1; return; end
        if (c == 8'hE0) begin m_ext = 1; return; end
        is_sh = (c == 8'h12 || c == 8'h59) && !m_ext;
        if (m_brk) begin
            if (is_sh) m_shift = 0;
        end else if (is_sh) m_shift = 1;
        else if (!m_ext && c == 8'h58) m_caps = !m_caps;
        else if (ref_xlate(c, ch) && !m_done) begin
            m_msg[m_cnt] = ch;
            m_known[m_cnt] = 1;
            if (m_cnt == 15) m_done = 1; else m_cnt++;
        end
        m_brk = 0;
        m_ext = 0;
    endtask

    task automatic compare(input string tag);
        bit bad = 0;
        checks++;
        if (done !== m_done) bad = 1;
        for (int i = 0; i < 16; i++)
            if (m_known[i] && msg[i*8 +: 8] !== m_msg[i]) bad = 1;
        if (bad) begin
            errors++;
            $display("FAIL %s: actual msg=%h done=%b, expected done=%b byte[%0d]=%h",
                     tag, msg, done, m_done, m_cnt, m_msg[m_cnt]);
        end
    endtask

    task automatic send(input logic [7:0] c, input string tag);
        scan = c; vld = 1'b1;
        @(negedge clk); vld = 1'b0; compare(tag);
        @(negedge clk); compare(tag);
        @(negedge clk); compare(tag);
        @(negedge clk); model_apply(c); compare(tag);
        @(negedge clk); compare(tag);
    endtask

    // second strobe lands while the first byte is being fetched
    task automatic send_pair(input logic [7:0] a, input logic [7:0] b, input string tag);
        scan = a; vld = 1'b1;
        @(negedge clk); scan = b; compare(tag);
        @(negedge clk); vld = 1'b0; compare(tag);
        @(negedge clk); compare(tag);
        @(negedge clk); model_apply(a); compare(tag);
        @(negedge clk); compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_done = 0; m_shift = 0; m_caps = 0; m_brk = 0; m_ext = 0;
        compare(tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_known[i] = 0; m_msg[i] = 8'h00; end
        @(negedge clk);
        do_reset("R12 reset state");

        send(8'h1C, "R12 caps off after reset");
        send(8'h12, "R8 shift press");
        send(8'h32, "R2 shift letter");
        send(8'hF0, "R8 break prefix");
        send(8'h12, "R8 shift release");
        send(8'h21, "R2 lower after release");
        send(8'h58, "R10 caps press");
        send(8'hF0, "R10 caps break");
        send(8'h58, "R10 caps release ignored");
        send(8'h23, "R2 caps letter");
        send(8'h12, "R8 shift press");
        send(8'h24, "R2 shift and caps");
        send(8'hF0, "R8 break");
        send(8'h59, "R8 right shift release");
        send(8'h2B, "R2 caps only");
        send(8'h58, "R10 caps off");
        send(8'h16, "R3 digit");
        send(8'h12, "R3 shift");
        send(8'h1E, "R3 shifted digit");
        send(8'hF0, "R8 break");
        send(8'h12, "R8 release");
        send(8'hF0, "R8 break letter");
        send(8'h1C, "R8 release makes no char");
        send(8'h05, "R11 unmapped");
        send(8'h29, "R4 space");
        send(8'h66, "R4 backspace");
        send(8'h0D, "R4 tab");
        send(8'h5A, "R4 enter");
        send(8'h76, "R4 escape");
        send(8'hE0, "R4 ext prefix");
        send(8'h71, "R4 extended delete");
        send(8'hE0, "R11 ext prefix");
        send(8'h6B, "R11 unmapped extended");
        send(8'h71, "R9 prefix consumed");
        send_pair(8'h1C, 8'h32, "R1 busy strobe ignored");
        if (done !== 1'b1) begin
            errors++;
            $display("FAIL R5 sixteenth char: actual done=%b expected 1", done);
        end
        checks++;
        if (msg[7:0] !== 8'h61 || msg[127:120] !== 8'h61 || msg[15:8] !== 8'h42) begin
            errors++;
            $display("FAIL R5 byte order: actual %h expected low 4261 high 61", msg);
        end
        checks++;
        send(8'h3D, "R6 char after done ignored");
        do_reset("R7 reset keeps message");
        send(8'h3D, "R7 first after reset");
        send(8'h12, "R3 shift");
        send(8'h3D, "R7 second after reset");
        repeat (3) @(negedge clk);
        compare("R7 old bytes retained");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule